// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Capture

This block merges eight independent reset requests into a single system reset that the rest of the chip uses. The requests are power-on, brown-out, the external master-clear pin, a software reset instruction, a watchdog timeout, a trap conflict, an illegal-opcode / uninitialized-register / security fault, and a configuration mismatch. All requests arrive as synchronous digital levels. Any analog supply sensing happens outside this block.

The master-clear pin is debounced by a glitch filter before it may request a reset. When the last request goes away, the system reset is held for a fixed number of clocks and is then released on a clock edge.

An 8-bit cause register records which sources caused each reset. Every bit is sticky, and software can read and write it over a one-register bus. A power-on request wipes the register down to just the power-on bit. A software write only changes status and never causes a reset. When hardware sets a bit in the same cycle that software writes it, the hardware set wins.

Top module: `reset_cause_ctl`

## Requirements
- R1: Whenever any request is active (the master-clear pin counted once its filter accepts it), `sysRst` is 1 in that same cycle.
- R2: After the last active request drops, `sysRst` stays 1 for exactly HOLD_CYC (default 16) more rising edges. It falls just after a clock edge.
- R3: Each source sets its own bit of the cause register on the edge where its request is sampled. The bit map is: bit0 power-on, bit1 brown-out, bit2 software, bit3 watchdog, bit4 illegal-opcode/security, bit5 configuration mismatch, bit6 master-clear, bit7 trap conflict.
- R4: A power-on request leaves the cause register at exactly 8'h01 on the edge after it is sampled.
- R5: Cause bits other than bit0 keep their value across non-power-on resets until software changes them.
- R6: On a rising edge with `regWe`=1 and no power-on request, `regWdata` is loaded into the cause register. The register value is visible on `regRdata`.
- R7: A software write of any value, including a value with bits set, never asserts `sysRst`.
- R8: The master-clear pin must be sampled at 1 on FILT_LEN (default 4) consecutive edges before it requests a reset. A shorter pulse does not assert `sysRst` and does not set bit6.
- R9: When several sources are active in the same cycle, every one of their bits is set.
- R10: If a hardware set and a software write hit the same edge, every bit set by hardware ends at 1, whatever the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porReq | input | 1 | Power-on reset request, active high |
| borReq | input | 1 | Brown-out reset request |
| mclrPin | input | 1 | External master-clear pin level, 1 = reset asked |
| swReq | input | 1 | Software reset instruction request |
| wdtReq | input | 1 | Watchdog timeout request |
| trapReq | input | 1 | Trap conflict request |
| illegalReq | input | 1 | Illegal opcode / uninitialized register / security request |
| cfgReq | input | 1 | Configuration mismatch request |
| regWe | input | 1 | Cause register write strobe |
| regWdata | input | 8 | Cause register write data |
| regRdata | output | 8 | Cause register read data |
| sysRst | output | 1 | System reset output, active high |

## Verification
The assertions assume that every request input and the register bus are synchronous to `clk`. They also assume that the power-on request is held high from time zero through the first clock edges, because that request is what initializes the hold counter, the filter and the flags. The bench drives all inputs a short delay after a rising edge and raises the power-on request before time zero. Between scenarios it waits for `sysRst` to drain and clears the flags by a write, so each scenario starts from a known register value.

// File: rtl/rstCausePkg.sv
package rstCausePkg;
  localparam int NSRC      = 8;
  localparam int BIT_POR   = 0;
  localparam int BIT_BOR   = 1;
  localparam int BIT_SW    = 2;
  localparam int BIT_WDT   = 3;
  localparam int BIT_ILL   = 4;
  localparam int BIT_CFG   = 5;
  localparam int BIT_MCLR  = 6;
  localparam int BIT_TRAP  = 7;

  typedef struct packed {
    logic [NSRC-1:0] hwSet;
    logic            porWipe;
  } causeStrobe_t;
endpackage

// File: rtl/pinFilter.sv
module pinFilter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pinIn,
  output logic pinOk
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst || !pinIn) runCnt <= '0;
    else if (runCnt != FULL) runCnt <= runCnt + 1'b1;
  end

  assign pinOk = (runCnt == FULL);

  // R8
  pin_held_chk: assert property (@(posedge clk) disable iff (rst)
    pinOk |-> $past(pinIn));
endmodule

// File: rtl/rstSeqCtl.sv
module rstSeqCtl
  import rstCausePkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic            clk,
  input  logic [NSRC-1:0] srcReq,
  output logic            sysRst,
  output causeStrobe_t    strobe
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_CYC);

  logic          anyReq;
  logic [HW-1:0] holdCnt;

  assign anyReq = |srcReq;

  always_ff @(posedge clk) begin
    if (anyReq) holdCnt <= HOLD_LD;
    else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  assign sysRst = anyReq || (holdCnt != '0);

  assign strobe.hwSet   = srcReq;
  assign strobe.porWipe = srcReq[BIT_POR];

  // R1
  req_rst_chk: assert property (@(posedge clk) disable iff (srcReq[BIT_POR])
    (|$past(srcReq)) |-> sysRst);
  // R2
  release_quiet_chk: assert property (@(posedge clk) disable iff (srcReq[BIT_POR])
    $fell(sysRst) |-> !(|$past(srcReq)));
  // R2
  hold_range_chk: assert property (@(posedge clk) disable iff (srcReq[BIT_POR])
    holdCnt <= HOLD_LD);
endmodule

// File: rtl/causeFlags.sv
module causeFlags
  import rstCausePkg::*;
(
  input  logic            clk,
  input  causeStrobe_t    strobe,
  input  logic            regWe,
  input  logic [NSRC-1:0] regWdata,
  output logic [NSRC-1:0] flags
);
  logic [NSRC-1:0] baseVal;

  assign baseVal = regWe ? regWdata : flags;

  always_ff @(posedge clk) begin
    if (strobe.porWipe) flags <= NSRC'(1) << BIT_POR;
    else                flags <= baseVal | strobe.hwSet;
  end

  // R3
  hw_set_chk: assert property (@(posedge clk) disable iff (strobe.porWipe)
    (|strobe.hwSet) |=> ((flags & $past(strobe.hwSet)) == $past(strobe.hwSet)));
  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (strobe.porWipe)
    (!regWe && strobe.hwSet == '0) |=> $stable(flags));
  // R4
  por_wipe_chk: assert property (@(posedge clk) disable iff (strobe.porWipe)
    $fell(strobe.porWipe) |-> flags == (NSRC'(1) << BIT_POR));
endmodule

// File: rtl/reset_cause_ctl.sv
module reset_cause_ctl
  import rstCausePkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int HOLD_CYC = 16
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       borReq,
  input  logic       mclrPin,
  input  logic       swReq,
  input  logic       wdtReq,
  input  logic       trapReq,
  input  logic       illegalReq,
  input  logic       cfgReq,
  input  logic       regWe,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       sysRst
);
  logic            mclrOk;
  logic [NSRC-1:0] srcReq;
  causeStrobe_t    strobe;

  pinFilter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(porReq), .pinIn(mclrPin), .pinOk(mclrOk)
  );

  always_comb begin
    srcReq           = '0;
    srcReq[BIT_POR]  = porReq;
    srcReq[BIT_BOR]  = borReq;
    srcReq[BIT_SW]   = swReq;
    srcReq[BIT_WDT]  = wdtReq;
    srcReq[BIT_ILL]  = illegalReq;
    srcReq[BIT_CFG]  = cfgReq;
    srcReq[BIT_MCLR] = mclrOk;
    srcReq[BIT_TRAP] = trapReq;
  end

  rstSeqCtl #(.HOLD_CYC(HOLD_CYC)) u_ctl (
    .clk(clk), .srcReq(srcReq), .sysRst(sysRst), .strobe(strobe)
  );

  causeFlags u_flags (
    .clk(clk), .strobe(strobe), .regWe(regWe), .regWdata(regWdata),
    .flags(regRdata)
  );
endmodule

// File: tb/test_reset_cause_ctl.sv
module test_reset_cause_ctl;
  logic       clk = 1'b0;
  logic       porReq = 1'b1;
  logic       borReq = 1'b0, mclrPin = 1'b0, swReq = 1'b0, wdtReq = 1'b0;
  logic       trapReq = 1'b0, illegalReq = 1'b0, cfgReq = 1'b0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       sysRst;

  int nChk = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  reset_cause_ctl i_reset_cause_ctl (
    .clk(clk), .porReq(porReq), .borReq(borReq), .mclrPin(mclrPin),
    .swReq(swReq), .wdtReq(wdtReq), .trapReq(trapReq),
    .illegalReq(illegalReq), .cfgReq(cfgReq), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .sysRst(sysRst)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    #0;
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearFlags();
    tick(20);
    regWe = 1'b1; regWdata = 8'h00;
    tick();
    regWe = 1'b0;
  endtask

  task automatic testPor();
    tick(3);
    porReq = 1'b0;
    #1 check("R4 flags after power-on", regRdata, 8'h01);
    check("R1 reset during power-on hold", {7'd0, sysRst}, 8'd1);
  endtask

  task automatic testHold();
    clearFlags();
    wdtReq = 1'b1;
    #1 check("R1 same-cycle assert", {7'd0, sysRst}, 8'd1);
    tick();
    wdtReq = 1'b0;
    check("R3 watchdog bit3", regRdata, 8'h08);
    for (int i = 0; i < 15; i++) begin
      tick();
      check("R2 still held", {7'd0, sysRst}, 8'd1);
    end
    tick();
    check("R2 released after 16", {7'd0, sysRst}, 8'd0);
    tick(3);
    check("R5 flag survives reset", regRdata, 8'h08);
  endtask

  task automatic testSources();
    clearFlags();
    borReq = 1'b1; tick(); borReq = 1'b0;
    check("R3 brown-out bit1", regRdata, 8'h02);
    clearFlags();
    swReq = 1'b1; tick(); swReq = 1'b0;
    check("R3 software bit2", regRdata, 8'h04);
    clearFlags();
    illegalReq = 1'b1; tick(); illegalReq = 1'b0;
    check("R3 illegal bit4", regRdata, 8'h10);
    clearFlags();
    cfgReq = 1'b1; tick(); cfgReq = 1'b0;
    check("R3 config bit5", regRdata, 8'h20);
    clearFlags();
    trapReq = 1'b1; tick(); trapReq = 1'b0;
    check("R3 trap bit7", regRdata, 8'h80);
  endtask

  task automatic testMulti();
    clearFlags();
    borReq = 1'b1; trapReq = 1'b1; cfgReq = 1'b1;
    tick();
    borReq = 1'b0; trapReq = 1'b0; cfgReq = 1'b0;
    check("R9 multiple sources", regRdata, 8'hA2);
  endtask

  task automatic testSoftware();
    clearFlags();
    regWe = 1'b1; regWdata = 8'h5A;
    #1 check("R7 no reset on write cycle", {7'd0, sysRst}, 8'd0);
    tick();
    regWe = 1'b0;
    check("R6 write readback", regRdata, 8'h5A);
    check("R7 no reset after write", {7'd0, sysRst}, 8'd0);
    tick(3);
    check("R7 still no reset", {7'd0, sysRst}, 8'd0);
    regWe = 1'b1; regWdata = 8'h00;
    tick();
    regWe = 1'b0;
    check("R6 clear readback", regRdata, 8'h00);
  endtask

  task automatic testPriority();
    clearFlags();
    regWe = 1'b1; regWdata = 8'hFF;
    tick();
    regWdata = 8'h00; wdtReq = 1'b1;
    tick();
    regWe = 1'b0; wdtReq = 1'b0;
    check("R10 hardware wins", regRdata, 8'h08);
  endtask

  task automatic testFilter();
    clearFlags();
    mclrPin = 1'b1;
    tick(3);
    check("R8 no reset after 3 clocks", {7'd0, sysRst}, 8'd0);
    mclrPin = 1'b0;
    tick(3);
    check("R8 short pulse ignored", {7'd0, sysRst}, 8'd0);
    check("R8 short pulse no flag", regRdata, 8'h00);
    mclrPin = 1'b1;
    tick(3);
    check("R8 not yet", {7'd0, sysRst}, 8'd0);
    tick();
    check("R8 accepted after 4", {7'd0, sysRst}, 8'd1);
    tick();
    mclrPin = 1'b0;
    check("R3 master-clear bit6", regRdata, 8'h40);
  endtask

  task automatic testPorWipe();
    clearFlags();
    regWe = 1'b1; regWdata = 8'hFE;
    tick();
    regWe = 1'b0;
    porReq = 1'b1; borReq = 1'b1;
    tick();
    porReq = 1'b0; borReq = 1'b0;
    check("R4 wipe to power-on only", regRdata, 8'h01);
  endtask

  initial begin
    tick(150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    testPor();
    testHold();
    testSources();
    testMulti();
    testSoftware();
    testPriority();
    testFilter();
    testPorWipe();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule